// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects eight interrupt request lines and raises one registered interrupt output whenever an unmasked request outranks everything currently in service. Ranking starts at a programmable base position and wraps around modulo eight, so software can rotate priority. That base can be moved through end-of-interrupt commands, through an explicit command, or automatically on acknowledge. Each line is latched on a rising edge or follows its level. The choice comes from a per-line trigger-select register, and a fixed per-instance mask decides which lines may be set to level.

Software talks to the block through a byte-wide port with one address bit. Address 0 takes the initialization word, control words and priority commands. Address 1 takes the follow-up initialization words, and in normal operation it takes the mask. A host acknowledge input moves the winning request into service. The output `int_vec` combines the programmed vector base with the number of the winning line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted, `int_out` is 0, `trig_q` is 0, and reads of both addresses return 0.
- R2: A line whose trigger bit is 0 (edge) sets its request bit only when it is high in a cycle after a low cycle; holding it high does not set the bit again. A line whose trigger bit is 1 (level) has its request bit equal to the input in every cycle.
- R3: A trigger-select write stores `trig_wdata & TRIG_MASK`; with the default mask 8'hF8, writing 8'h0F reads back as 8'h08.
- R4: An address-0 write with bit 4 set clears the request, mask and in-service registers and all mode flags, but keeps the trigger register. Its bit 0 means a mode word follows, and its bit 1 means single (no link word). The next address-1 write stores bits 7:3 as the vector base. Then come a link word (if not single) and a mode word (if bit 0 was set), after which address-1 writes load the mask. `int_vec` is {vector base bits 7:3, winning line}.
- R5: In the mode word, bit 1 turns on automatic end of interrupt: an acknowledge sets no in-service bit. A priority command with bits 7:5 = 100 turns on rotate-on-auto-EOI, after which each acknowledge moves the base to the acknowledged line plus one. The value 000 turns it off.
- R6: An address-1 write in normal operation loads the mask register, and a masked request never raises `int_out`.
- R7: The winner is the first unmasked request found from the base upward (mod 8). The interrupt is raised only if its offset from the base is strictly below that of the first in-service bit.
- R8: An address-0 write with bits 4:3 = 00 and bits 7:5 = 001 clears the in-service bit found first from the base. With bits 7:5 = 101 it also moves the base to that line plus one.
- R9: Bits 7:5 = 011 clears the in-service bit named by bits 2:0. The value 111 clears that bit and sets the base to it plus one. The value 110 sets the base to bits 2:0 plus one.
- R10: A control word (bits 4:3 = 01) with bit 6 set loads bit 5 into special mask mode. In that mode, masked lines are left out of the in-service set before the comparison of R7.
- R11: In a control word, bit 1 set makes bit 0 choose the address-0 read: 1 gives in-service, 0 gives request. Bit 2 arms poll, so the next read returns the winning line number (or 7 if there is none), clears that line's request and in-service bits, and disarms poll.
- R12: An acknowledge with a winner present sets that line's in-service bit (unless auto EOI is on). It clears the request bit only for edge-triggered lines.
- R13: An end-of-interrupt command issued while no in-service bit is set changes neither the in-service register nor the base.
- R14: `int_out` is registered: it reflects the register state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register port address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (consumes a poll) |
| rd_data | output | 8 | Read data |
| ack | input | 1 | Host acknowledge of the current winner |
| trig_we | input | 1 | Trigger-select write strobe |
| trig_wdata | input | 8 | Trigger-select write data |
| trig_q | output | 8 | Trigger-select register |
| int_out | output | 1 | Registered interrupt request to the host |
| int_vec | output | 8 | Vector base and winning line |

## Verification
A wrong rotation base stays invisible until two requests or in-service bits compete. It then shows as the wrong line entering service or being polled, one cycle after the acknowledge or read, so the stimulus sets up competing requests after every base change. A stale in-service bit shows as `int_out` held low one cycle after a new request that should have nested. A lost request bit shows immediately on an address-0 read with the request view selected. Errors in the initialization step counter show as the mask failing to load, or the vector base landing in the wrong word.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = IDX_W + 1;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_LINK, ST_MODE} init_st_e;

  typedef struct packed {
    logic rsel;
    logic poll;
    logic smm;
    logic aeoi;
    logic raeoi;
    logic sfnm;
    logic need4;
    logic single;
  } mode_t;

  // offset from base of first set bit, LINES when empty
  function automatic logic [OFS_W-1:0] first_from(input logic [LINES-1:0] v,
                                                  input logic [IDX_W-1:0] base);
    logic [OFS_W-1:0] r;
    r = OFS_W'(LINES);
    for (int i = LINES - 1; i >= 0; i--)
      if (v[base + IDX_W'(i)]) r = OFS_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/pic_trig_reg.sv
module pic_trig_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = 8'hF8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb q_nx = wdata & MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  q <= '0;
    else if (we) q <= q_nx;

  // R3
  trig_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == ($past(wdata) & MASK));
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
#(
  parameter bit PRIMARY  = 1'b1,
  parameter int CASC_BIT = 2
) (
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] imr,
  input  logic [LINES-1:0] isr,
  input  logic [IDX_W-1:0] base,
  input  logic             smm,
  input  logic             sfnm,
  output logic             valid,
  output logic [IDX_W-1:0] id
);
  logic [LINES-1:0] cur_set;
  logic [LINES-1:0] cur_fin;
  logic [OFS_W-1:0] req_ofs;
  logic [OFS_W-1:0] cur_ofs;

  always_comb cur_set = smm ? (isr & ~imr) : isr;

  generate
    if (PRIMARY) begin : g_nest
      always_comb begin
        cur_fin = cur_set;
        if (sfnm) cur_fin[CASC_BIT] = 1'b0;
      end
    end else begin : g_plain
      logic unused_sfnm;
      always_comb unused_sfnm = sfnm;
      always_comb cur_fin = cur_set;
    end
  endgenerate

  always_comb begin
    req_ofs = first_from(irr & ~imr, base);
    cur_ofs = first_from(cur_fin, base);
    valid   = !req_ofs[OFS_W-1] && (req_ofs < cur_ofs);
    id      = req_ofs[IDX_W-1:0] + base;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8,
  parameter bit         PRIMARY   = 1'b1,
  parameter int         CASC_BIT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       ack,
  input  logic       trig_we,
  input  logic [7:0] trig_wdata,
  output logic [7:0] trig_q,
  output logic       int_out,
  output logic [7:0] int_vec
);
  localparam int VB_W = 8 - IDX_W;

  logic [LINES-1:0] irr, imr, isr, last, irr_nx, imr_nx, isr_nx, last_nx;
  logic [IDX_W-1:0] base, base_nx, win_id, eoi_idx;
  logic [VB_W-1:0]  vbase, vbase_nx;
  mode_t            mode, mode_nx;
  init_st_e         st, st_nx;
  logic             win_valid;
  logic [OFS_W-1:0] eoi_ofs;
  logic             wr0, wr1, poll_rd;

  pic_trig_reg #(.W(LINES), .MASK(TRIG_MASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .we(trig_we), .wdata(trig_wdata), .q(trig_q));

  pic_resolve #(.PRIMARY(PRIMARY), .CASC_BIT(CASC_BIT)) u_res (
    .irr(irr), .imr(imr), .isr(isr), .base(base), .smm(mode.smm),
    .sfnm(mode.sfnm), .valid(win_valid), .id(win_id));

  always_comb begin
    wr0     = wr_en && !addr;
    wr1     = wr_en && addr;
    poll_rd = rd_en && mode.poll;
    eoi_ofs = first_from(isr, base);
    eoi_idx = eoi_ofs[IDX_W-1:0] + base;
  end

  always_comb begin
    irr_nx = irr; imr_nx = imr; isr_nx = isr; last_nx = irq_in;
    base_nx = base; vbase_nx = vbase; mode_nx = mode; st_nx = st;
    // acknowledge
    if (ack && win_valid) begin
      if (mode.aeoi) begin
        if (mode.raeoi) base_nx = win_id + 1'b1;
      end else begin
        isr_nx[win_id] = 1'b1;
      end
      if (!trig_q[win_id]) irr_nx[win_id] = 1'b0;
    end
    // poll read
    if (poll_rd) begin
      mode_nx.poll = 1'b0;
      if (win_valid) begin
        irr_nx[win_id] = 1'b0;
        isr_nx[win_id] = 1'b0;
      end
    end
    // control words and commands
    if (wr0 && !wdata[4]) begin
      if (wdata[3]) begin
        if (wdata[2]) mode_nx.poll = 1'b1;
        if (wdata[1]) mode_nx.rsel = wdata[0];
        if (wdata[6]) mode_nx.smm  = wdata[5];
      end else begin
        unique case (wdata[7:5])
          3'd0, 3'd4: mode_nx.raeoi = wdata[7];
          3'd1, 3'd5:
            if (!eoi_ofs[OFS_W-1]) begin
              isr_nx[eoi_idx] = 1'b0;
              if (wdata[7]) base_nx = eoi_idx + 1'b1;
            end
          3'd3: isr_nx[wdata[2:0]] = 1'b0;
          3'd6: base_nx = wdata[2:0] + 1'b1;
          3'd7: begin
            isr_nx[wdata[2:0]] = 1'b0;
            base_nx = wdata[2:0] + 1'b1;
          end
          default: ;
        endcase
      end
    end
    // address-1 words
    if (wr1) begin
      unique case (st)
        ST_RUN:  imr_nx = wdata;
        ST_BASE: begin
          vbase_nx = wdata[7:IDX_W];
          st_nx = mode.single ? (mode.need4 ? ST_MODE : ST_RUN) : ST_LINK;
        end
        ST_LINK: st_nx = mode.need4 ? ST_MODE : ST_RUN;
        ST_MODE: begin
          mode_nx.sfnm = wdata[4];
          mode_nx.aeoi = wdata[1];
          st_nx = ST_RUN;
        end
        default: st_nx = ST_RUN;
      endcase
    end
    // request sampling
    for (int i = 0; i < LINES; i++) begin
      if (trig_q[i])                irr_nx[i] = irq_in[i];
      else if (irq_in[i] && !last[i]) irr_nx[i] = 1'b1;
    end
    // initialization overrides everything
    if (wr0 && wdata[4]) begin
      irr_nx = '0; imr_nx = '0; isr_nx = '0; last_nx = '0;
      base_nx = '0; vbase_nx = '0; mode_nx = '0;
      mode_nx.need4  = wdata[0];
      mode_nx.single = wdata[1];
      st_nx = ST_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irr <= '0; imr <= '0; isr <= '0; last <= '0;
      base <= '0; vbase <= '0; mode <= '0; st <= ST_RUN;
      int_out <= 1'b0;
    end else begin
      irr <= irr_nx; imr <= imr_nx; isr <= isr_nx; last <= last_nx;
      base <= base_nx; vbase <= vbase_nx; mode <= mode_nx; st <= st_nx;
      int_out <= win_valid;
    end

  always_comb begin
    if (mode.poll)  rd_data = win_valid ? 8'(win_id) : 8'h07;
    else if (addr)  rd_data = imr;
    else            rd_data = mode.rsel ? isr : irr;
    int_vec = {vbase, win_id};
  end

  // R4
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wdata[4]) |=> (irr == '0 && isr == '0 && imr == '0 && st == ST_BASE));
  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && st == ST_RUN) |=> imr == $past(wdata));
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(imr) == 8'hFF) |-> !int_out);
  // R7
  win_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irr[win_id] && !imr[win_id]));
  // R12
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !mode.aeoi && !wr_en && !poll_rd) |=> isr[$past(win_id)]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       wr_en, addr, rd_en, ack, trig_we;
  logic [7:0] wdata, trig_wdata;
  logic [7:0] rd_data, trig_q, int_vec;
  logic       int_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .ack(ack),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_q(trig_q),
    .int_out(int_out), .int_vec(int_vec));

  localparam logic [2:0] OP_WR = 3'd0, OP_IN = 3'd1, OP_ACK = 3'd2,
                         OP_RD = 3'd3, OP_INT = 3'd4, OP_TW = 3'd5;
  localparam int NV = 58;
  // {op, addr, data, expected}
  localparam logic [19:0] TBL [NV] = '{
    {OP_WR,1'b0,8'h13,8'h00},  // R4 init: single, mode word follows
    {OP_WR,1'b1,8'h20,8'h00},  // R4 vector base
    {OP_WR,1'b1,8'h00,8'h00},  // R4 mode word, plain
    {OP_WR,1'b1,8'h00,8'h00},  // R6 mask load
    {OP_RD,1'b1,8'h00,8'h00},  // R4 mask cleared
    {OP_IN,1'b0,8'h05,8'h00},  // R2 edges on 0 and 2
    {OP_RD,1'b0,8'h00,8'h05},  // R2
    {OP_INT,1'b0,8'h00,8'h01}, // R14
    {OP_ACK,1'b0,8'h00,8'h00}, // R12 line 0 in service
    {OP_RD,1'b0,8'h00,8'h04},  // R12 edge request cleared
    {OP_WR,1'b0,8'h0B,8'h00},  // R11 select in-service view
    {OP_RD,1'b0,8'h00,8'h01},  // R11
    {OP_INT,1'b0,8'h00,8'h00}, // R7 line 2 below line 0
    {OP_WR,1'b0,8'h20,8'h00},  // R8 non-specific EOI
    {OP_RD,1'b0,8'h00,8'h00},  // R8
    {OP_INT,1'b0,8'h00,8'h01}, // R7
    {OP_WR,1'b1,8'h04,8'h00},  // R6 mask line 2
    {OP_INT,1'b0,8'h00,8'h00}, // R6
    {OP_WR,1'b1,8'h00,8'h00},
    {OP_ACK,1'b0,8'h00,8'h00}, // R12 line 2 in service
    {OP_WR,1'b0,8'h0A,8'h00},  // R11 request view
    {OP_RD,1'b0,8'h00,8'h00},  // R2 held high, no re-trigger
    {OP_IN,1'b0,8'h00,8'h00},
    {OP_IN,1'b0,8'h01,8'h00},
    {OP_RD,1'b0,8'h00,8'h01},  // R2
    {OP_INT,1'b0,8'h00,8'h01}, // R7 nesting over line 2
    {OP_WR,1'b0,8'hA0,8'h00},  // R8 rotating EOI, base 3
    {OP_WR,1'b0,8'h0B,8'h00},
    {OP_RD,1'b0,8'h00,8'h00},  // R8
    {OP_WR,1'b0,8'hC4,8'h00},  // R9 base 5
    {OP_ACK,1'b0,8'h00,8'h00},
    {OP_IN,1'b0,8'h00,8'h00},
    {OP_IN,1'b0,8'h80,8'h00},
    {OP_INT,1'b0,8'h00,8'h01}, // R7 line 7 outranks line 0 at base 5
    {OP_WR,1'b0,8'h60,8'h00},  // R9 specific EOI line 0
    {OP_RD,1'b0,8'h00,8'h00},  // R9
    {OP_ACK,1'b0,8'h00,8'h00},
    {OP_WR,1'b0,8'hE7,8'h00},  // R9 specific rotate line 7, base 0
    {OP_RD,1'b0,8'h00,8'h00},  // R9
    {OP_IN,1'b0,8'h00,8'h00},
    {OP_IN,1'b0,8'h81,8'h00},
    {OP_ACK,1'b0,8'h00,8'h00},
    {OP_RD,1'b0,8'h00,8'h01},  // R9 base 0 picks line 0
    {OP_WR,1'b0,8'h20,8'h00},
    {OP_WR,1'b0,8'hA0,8'h00},  // R13 EOI with empty in-service
    {OP_RD,1'b0,8'h00,8'h00},  // R13
    {OP_IN,1'b0,8'h80,8'h00},
    {OP_IN,1'b0,8'h81,8'h00},
    {OP_ACK,1'b0,8'h00,8'h00},
    {OP_RD,1'b0,8'h00,8'h01},  // R13 base unchanged
    {OP_INT,1'b0,8'h00,8'h00}, // R7
    {OP_WR,1'b1,8'h01,8'h00},
    {OP_WR,1'b0,8'h68,8'h00},  // R10 special mask on
    {OP_INT,1'b0,8'h00,8'h01}, // R10
    {OP_WR,1'b0,8'h48,8'h00},  // R10 special mask off
    {OP_INT,1'b0,8'h00,8'h00}, // R10
    {OP_WR,1'b1,8'h00,8'h00},
    {OP_TW,1'b0,8'h0F,8'h08}   // R3
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_wr(logic a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d; tick(); wr_en = 1'b0;
  endtask

  task automatic do_in(logic [7:0] d);
    irq_in = d; tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic chk_rd(logic a, logic [7:0] e, string tag);
    addr = a; rd_en = 1'b1; #1;
    chk(tag, rd_data, e);
    tick(); rd_en = 1'b0;
  endtask

  task automatic chk_int(logic e, string tag);
    tick(); chk(tag, {7'b0, int_out}, {7'b0, e});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; wr_en = 0; addr = 0; wdata = '0;
    rd_en = 0; ack = 0; trig_we = 0; trig_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 int", {7'b0, int_out}, 8'h00);
    chk("R1 trig", trig_q, 8'h00);
    chk("R1 read", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [2:0] op;
      logic       a;
      logic [7:0] d, e;
      string      tag;
      {op, a, d, e} = TBL[k];
      tag = $sformatf("table row %0d", k);
      case (op)
        OP_WR:  do_wr(a, d);
        OP_IN:  do_in(d);
        OP_ACK: do_ack();
        OP_RD:  chk_rd(a, e, tag);
        OP_INT: chk_int(e[0], tag);
        default: begin
          trig_we = 1'b1; trig_wdata = d; tick(); trig_we = 1'b0;
          chk(tag, trig_q, e);
        end
      endcase
    end

    // level lines follow the input (line 3 is level now)
    do_wr(0, 8'h0A);
    chk_rd(0, 8'h80, "R2 before level");
    do_in(8'h89); chk_rd(0, 8'h88, "R2 level high");
    do_in(8'h81); chk_rd(0, 8'h80, "R2 level low");
    do_in(8'h89);
    do_wr(0, 8'h20);
    do_ack();
    chk_rd(0, 8'h88, "R12 level request kept");

    // poll
    do_wr(0, 8'h20);
    do_in(8'h81);
    do_wr(0, 8'h0C);
    chk_rd(0, 8'h07, "R11 poll winner 7");
    chk_rd(0, 8'h00, "R11 poll cleared request");
    do_wr(0, 8'h0C);
    chk_rd(0, 8'h07, "R11 poll none");
    chk_rd(0, 8'h00, "R11 poll disarmed");

    // cascaded init with mode word, auto EOI
    do_in(8'h00);
    do_wr(1, 8'h55);
    do_wr(0, 8'h11);
    chk_rd(1, 8'h00, "R4 mask cleared by init");
    do_wr(1, 8'h08);
    do_wr(1, 8'h04);
    do_wr(1, 8'h02);
    chk("R4 trig kept", trig_q, 8'h08);
    do_wr(1, 8'h00);
    do_in(8'h02);
    #1 chk("R4 vector", int_vec, 8'h09);
    chk_int(1'b1, "R14 raised");
    do_ack();
    chk_rd(0, 8'h00, "R5 request consumed");
    do_wr(0, 8'h0B);
    chk_rd(0, 8'h00, "R5 nothing in service");
    chk_int(1'b0, "R5 quiet");

    // rotate on auto EOI
    do_wr(0, 8'h80);
    do_in(8'h00); do_in(8'h01);
    do_ack();
    do_in(8'h00); do_in(8'h03);
    do_wr(0, 8'h0C);
    chk_rd(0, 8'h01, "R5 base rotated to 1");

    // single, no mode word
    do_wr(0, 8'h12);
    do_wr(1, 8'h00);
    do_wr(1, 8'h3C);
    chk_rd(1, 8'h3C, "R4 short sequence");

    // reset again
    addr = 1'b1; rst_n = 1'b0; #1;
    chk("R1 int again", {7'b0, int_out}, 8'h00);
    chk("R1 trig again", trig_q, 8'h00);
    chk("R1 mask again", rd_data, 8'h00);
    tick(); rst_n = 1'b1; tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule